// File: doc/BRIEF.md
# Two-Level Adaptive Synchronization Backoff Unit

Each core has one copy of this unit. It sits between the local cache and the network. It decides when the core's next synchronization read miss may leave. Every synchronization read request that arrives at this core from another core is taken as a sign of contention. Each such request grows a backoff amount by the current step size. Every N-th such request also grows the step size itself by a configured base step D. When the cache asks to issue a synchronization read miss, the unit holds the miss back for as many cycles as the backoff amount. It then grants the miss and clears the backoff amount. The step size is kept, so the unit carries what it learned about contention into the next miss.

Control is a two-state machine:
- `ST_IDLE`: no miss is being held.
- `ST_HOLD`: a miss is being delayed.

It has three transitions:
- **pass-through**: in `ST_IDLE`, with a request and a backoff of zero, the grant is issued in the same cycle and the unit stays in `ST_IDLE`.
- **arm**: in `ST_IDLE`, with a request and a non-zero backoff, the countdown is loaded and the unit enters `ST_HOLD`.
- **release**: in `ST_HOLD`, once the countdown reaches zero, the grant is issued and the unit returns to `ST_IDLE`.

The two counters sit in a separate tracker. An event counter inside the tracker marks every N-th hint.

Top module: `sync_backoff_unit`

## Requirements
- R1: Reset is synchronous and active low. It sets the backoff amount to 0, loads the step size from `cfg_step_i`, clears the hint counter and enters `ST_IDLE`. While the unit is idle, `miss_grant_o` and `busy_o` are low unless a request is present.
- R2: When the backoff amount is 0, a request on `miss_req_i` in `ST_IDLE` is granted in the same cycle, and `busy_o` stays low.
- R3: Each cycle with `remote_hint_i` high adds the step size to the backoff amount. The value added is the step size as it stood before that cycle.
- R4: With `cfg_period_i` = N > 0, the step size grows by `cfg_step_i` on hints number N, 2N, 3N and so on. With N = 0 the step size never changes.
- R5: Suppose a request is first seen in cycle t with a backoff amount of k > 0. Then `busy_o` is high in cycles t+1 through t+k, and `miss_grant_o` is high only in cycle t+k. The requester holds `miss_req_i` until the grant.
- R6: A delayed grant clears the backoff amount to 0 and leaves the step size unchanged.
- R7: A hint that arrives during `ST_HOLD` does not lengthen the countdown that is already running.
- R8: The backoff amount and the step size saturate at their all-ones values and never wrap.
- R9: A hint in the same cycle as a delayed grant is applied after the clear, so the next backoff equals the step size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| remote_hint_i | input | 1 | One-cycle pulse per remote synchronization read seen by this core |
| miss_req_i | input | 1 | Local cache wants to issue a synchronization read miss; held until granted |
| cfg_period_i | input | PER_W | Hints per step-size growth (N); 0 disables growth |
| cfg_step_i | input | STEP_W | Base step D; also the step size after reset |
| miss_grant_o | output | 1 | Miss may be issued this cycle |
| busy_o | output | 1 | A miss is being delayed |

## Verification
The bench reads the backoff amount indirectly, as the number of cycles from request to grant, across several combinations of period and step. A design that used the step size after its own update in the same cycle would show a longer delay. A design with an off-by-one in the N-th hint counter would show a shorter one. The directed tests cover the following:
- A hint during the countdown: a design that re-arms the countdown would grant late.
- A hint in the grant cycle: a design that let the clear win would then grant immediately.
- A long saturating run: a counter that wraps would give a small delay instead of the full ceiling.
- A miss right after a delayed grant: a design that failed to clear the backoff amount would delay this miss again.

// File: rtl/sbo_pkg.sv
package sbo_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } sbo_state_e;
endpackage

// File: rtl/sbo_hint_tracker.sv
module sbo_hint_tracker #(
    parameter int BACK_W = 12,
    parameter int STEP_W = 8,
    parameter int PER_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              hint_i,
    input  logic              clear_i,
    input  logic [PER_W-1:0]  period_i,
    input  logic [STEP_W-1:0] step_i,
    output logic [BACK_W-1:0] backoff_o,
    output logic [STEP_W-1:0] incr_o
);
    localparam logic [BACK_W-1:0] BACK_MAX = '1;
    localparam logic [STEP_W-1:0] STEP_MAX = '1;

    logic [BACK_W-1:0] backoff_q, back_base;
    logic [STEP_W-1:0] incr_q;
    logic [PER_W-1:0]  evt_q;
    logic [BACK_W:0]   back_sum;
    logic [STEP_W:0]   incr_sum;
    logic              nth_hit, chk_armed;

    assign nth_hit   = hint_i && (period_i != '0) && (evt_q == period_i - 1'b1);
    assign back_base = clear_i ? '0 : backoff_q;
    assign back_sum  = {1'b0, back_base} + (BACK_W+1)'(incr_q);
    assign incr_sum  = {1'b0, incr_q} + {1'b0, step_i};

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            backoff_q <= '0;
            incr_q    <= step_i;
            evt_q     <= '0;
            chk_armed <= 1'b0;
        end else begin
            chk_armed <= 1'b1;
            if (hint_i) begin
                backoff_q <= back_sum[BACK_W] ? BACK_MAX : back_sum[BACK_W-1:0];
            end else begin
                backoff_q <= back_base;
            end
            if (hint_i && (period_i != '0)) begin
                evt_q <= nth_hit ? '0 : evt_q + 1'b1;
            end
            if (nth_hit) begin
                incr_q <= incr_sum[STEP_W] ? STEP_MAX : incr_sum[STEP_W-1:0];
            end
        end
    end

    assign backoff_o = backoff_q;
    assign incr_o    = incr_q;

    assert_incr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chk_armed && !hint_i |=> incr_q == $past(incr_q));
    assert_incr_no_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chk_armed |=> incr_q >= $past(incr_q));
    assert_backoff_no_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chk_armed && hint_i && !clear_i |=> backoff_q >= $past(backoff_q));
endmodule

// File: rtl/sbo_delay_fsm.sv
module sbo_delay_fsm
    import sbo_pkg::*;
#(
    parameter int BACK_W = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic [BACK_W-1:0] backoff_i,
    output logic              grant_o,
    output logic              busy_o,
    output logic              clear_o
);
    sbo_state_e        state_q, state_d;
    logic [BACK_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i && (backoff_i != '0)) begin
                    state_d = ST_HOLD;
                    cnt_d   = backoff_i - 1'b1;
                end
            end
            ST_HOLD: begin
                if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        grant_o = 1'b0;
        busy_o  = 1'b0;
        clear_o = 1'b0;
        unique case (state_q)
            ST_IDLE: grant_o = req_i && (backoff_i == '0);
            ST_HOLD: begin
                busy_o  = 1'b1;
                grant_o = (cnt_q == '0);
                clear_o = (cnt_q == '0);
            end
            default: ;
        endcase
    end

    assert_arm_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q == ST_IDLE && req_i && backoff_i != '0
        |=> state_q == ST_HOLD && cnt_q == $past(backoff_i) - 1'b1);
    assert_countdown_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q == ST_HOLD && cnt_q != '0 |=> state_q == ST_HOLD && cnt_q == $past(cnt_q) - 1'b1);
    assert_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o && grant_o |=> state_q == ST_IDLE);
endmodule

// File: rtl/sync_backoff_unit.sv
module sync_backoff_unit #(
    parameter int BACK_W = 12,
    parameter int STEP_W = 8,
    parameter int PER_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              remote_hint_i,
    input  logic              miss_req_i,
    input  logic [PER_W-1:0]  cfg_period_i,
    input  logic [STEP_W-1:0] cfg_step_i,
    output logic              miss_grant_o,
    output logic              busy_o
);
    logic [BACK_W-1:0] backoff;
    logic [STEP_W-1:0] incr;
    logic              clear;

    sbo_hint_tracker #(.BACK_W(BACK_W), .STEP_W(STEP_W), .PER_W(PER_W)) u_track (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .hint_i   (remote_hint_i),
        .clear_i  (clear),
        .period_i (cfg_period_i),
        .step_i   (cfg_step_i),
        .backoff_o(backoff),
        .incr_o   (incr)
    );

    sbo_delay_fsm #(.BACK_W(BACK_W)) u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (miss_req_i),
        .backoff_i(backoff),
        .grant_o  (miss_grant_o),
        .busy_o   (busy_o),
        .clear_o  (clear)
    );

    assert_clear_on_grant_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o && miss_grant_o && !remote_hint_i |=> backoff == '0);
    assert_hint_at_grant_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o && miss_grant_o && remote_hint_i |=> backoff == BACK_W'($past(incr)));
    assert_pass_through_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        miss_grant_o && !busy_o |=> !busy_o);
endmodule

// File: tb/sync_backoff_unit_tb_top.sv
module sync_backoff_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       hint = 1'b0;
    logic       req = 1'b0;
    logic [3:0] per = '0;
    logic [7:0] stp = '0;
    logic       grant, busy;
    int         n_chk = 0;
    int         n_fail = 0;
    int         cyc = 0;

    always #2 clk = ~clk;

    sync_backoff_unit dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .remote_hint_i(hint), .miss_req_i(req),
        .cfg_period_i(per), .cfg_step_i(stp), .miss_grant_o(grant), .busy_o(busy)
    );

    localparam int NV = 5;
    localparam int VEC_PER[NV]  = '{3, 1, 0, 2, 4};
    localparam int VEC_STEP[NV] = '{2, 1, 3, 5, 0};
    localparam int VEC_HINT[NV] = '{5, 4, 4, 3, 6};
    localparam int VEC_EXP[NV]  = '{14, 10, 12, 20, 0};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input int p, input int s);
        @(negedge clk);
        rst_ni = 1'b0; req = 1'b0; hint = 1'b0;
        per = 4'(p); stp = 8'(s);
        repeat (2) @(negedge clk);
        rst_ni = 1'b1;
    endtask

    task automatic pulse_hints(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); hint = 1'b1;
            @(negedge clk); hint = 1'b0;
        end
    endtask

    // Measures request-to-grant latency; mid_hint>0 pulses a hint after that many waiting cycles
    task automatic measure(input int exp, input string tag, input bit hint_at_grant, input int mid_hint);
        int  lat;
        bit  busy_bad;
        lat = 0; busy_bad = 0;
        @(negedge clk); req = 1'b1; #1;
        if (busy) busy_bad = 1;
        while (!grant && lat < 6000) begin
            @(posedge clk); #1;
            hint = 1'b0;
            lat++;
            if (!busy) busy_bad = 1;
            if (mid_hint > 0 && lat == mid_hint) hint = 1'b1;
        end
        if (hint_at_grant) hint = 1'b1;
        @(posedge clk); #1;
        req = 1'b0; hint = 1'b0;
        check(lat == exp, {tag, " latency"}, lat, exp);
        check(!busy_bad, "R5 busy window", busy_bad, 0);
        #1; check(!busy && !grant, "R5 idle after grant", int'(busy), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset(2, 4);
        #1;
        check(!grant && !busy, "R1 outputs idle after reset", int'(grant | busy), 0);
        measure(0, "R1 R2 zero backoff after reset", 0, 0);

        // Table walk: R3 and R4 across period/step patterns
        for (int v = 0; v < NV; v++) begin
            do_reset(VEC_PER[v], VEC_STEP[v]);
            pulse_hints(VEC_HINT[v]);
            measure(VEC_EXP[v], $sformatf("R3 R4 vector %0d", v), 0, 0);
        end

        // R6: clear after delayed grant, step size kept (N=1, D=1 -> I=5 after 4 hints)
        do_reset(1, 1);
        pulse_hints(4);
        measure(10, "R4 step growth", 0, 0);
        measure(0, "R6 backoff cleared", 0, 0);
        pulse_hints(1);
        measure(5, "R6 step kept", 0, 0);

        // R7: hint mid-countdown does not extend
        do_reset(0, 4);
        pulse_hints(2);
        measure(8, "R7 no extension", 0, 3);
        measure(0, "R7 cleared after grant", 0, 0);

        // R9: hint in the grant cycle survives the clear
        do_reset(0, 3);
        pulse_hints(1);
        measure(3, "R9 first miss", 1, 0);
        measure(3, "R9 hint at grant counted", 0, 0);

        // R8: saturation of step (255) and backoff (4095)
        do_reset(1, 200);
        pulse_hints(20);
        measure(4095, "R8 backoff saturates", 0, 0);
        pulse_hints(1);
        measure(255, "R8 step saturates", 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule